// File: doc/BRIEF.md
# Non-Stalling Store Queue with Load Forwarding

This block sits between a processor's load/store port and its data cache. A store to a line that the cache does not hold with write ownership does not hold up the processor while it waits for that ownership. The store is logged in a short in-order queue and the processor moves on to its next operation in the following cycle. Each queued entry holds a word address, write data and a byte-enable mask. The oldest entry's address is presented to the coherence side. Once that side reports the line as owned, the entry is written into the cache. The queued bytes replace whatever the line held, and the entry is then released.

Loads are never delayed. The cache read port follows the load address. The returned word is merged byte by byte with every queued entry that targets the same word, so the processor always sees its own newest stores. A store to an owned line when the queue is empty goes straight to the cache. When the queue is full, a store is held off with a stall until space frees up.

Top module: `store_buffer`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, the queue is empty: stall_o, full_o, drain_pending_o and cache_wr_en_o are all 0.
- R2: A store (req_valid_i=1, req_we_i=1) that is neither direct nor refused by a full queue is appended at the clock edge. drain_pending_o is 1 from the next cycle onward, and stall_o stays 0 for that store.
- R3: A store issued when the queue is empty and req_owned_i=1 writes the cache in the same cycle. cache_wr_en_o=1 and the write port carries the store's address, data and byte enables. Nothing is queued.
- R4: When the queue is non-empty and drain_owned_i=1, the oldest entry appears on the write port in that cycle and is removed at the edge. Entries leave in the order they were stored.
- R5: When no store qualifies as direct and the queue is empty or drain_owned_i=0, cache_wr_en_o is 0.
- R6: load_data_o equals cache_rd_data_i with each byte lane b (bits 8b+7..8b) replaced by the data of the youngest queued entry whose address equals req_addr_i and whose byte-enable bit b is 1. cache_rd_addr_o equals req_addr_i.
- R7: full_o is 1 exactly when DEPTH entries are held. A store in a cycle with full_o=1 gets stall_o=1 and is not recorded, even if a drain happens in the same cycle.
- R8: A load (req_valid_i=1, req_we_i=0) never gets stall_o=1.
- R9: A store to an owned line (req_owned_i=1) while the queue is non-empty is queued behind the older entries, not written directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | AW | Word address of the request |
| req_wdata_i | input | DW | Store data |
| req_be_i | input | DW/8 | Store byte enables, bit b covers lane b |
| req_owned_i | input | 1 | Line of req_addr_i is held with write ownership |
| stall_o | output | 1 | Store refused this cycle, retry |
| full_o | output | 1 | Queue holds DEPTH entries |
| load_data_o | output | DW | Load result after forwarding |
| cache_rd_addr_o | output | AW | Cache read address |
| cache_rd_data_i | input | DW | Cache read data for cache_rd_addr_o, same cycle |
| drain_pending_o | output | 1 | Queue holds at least one entry |
| drain_addr_o | output | AW | Address of the oldest entry |
| drain_owned_i | input | 1 | Line of drain_addr_o is now owned |
| cache_wr_en_o | output | 1 | Cache write strobe |
| cache_wr_addr_o | output | AW | Cache write address |
| cache_wr_data_o | output | DW | Cache write data |
| cache_wr_be_o | output | DW/8 | Cache write byte enables |

## Verification
The assertions assume that the cache answers a read in the same cycle it is issued and that it accepts a write in every cycle. They also assume that drain_owned_i describes the line of drain_addr_o and that req_owned_i describes the line of req_addr_i. The bench models the cache as a word array. The read port is driven combinationally from that array, and every write strobe is applied at the clock edge, so neither assumption can be broken. The ownership inputs are free random bits, because the block must behave correctly for any ownership answer. Directed phases hold ownership low to fill the queue, and then raise it to empty the queue.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    WSRC_NONE   = 2'd0,
    WSRC_DIRECT = 2'd1,
    WSRC_DRAIN  = 2'd2
  } wsrc_e;
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              push_i,
  input  logic [AW-1:0]                     push_addr_i,
  input  logic [DW-1:0]                     push_data_i,
  input  logic [DW/8-1:0]                   push_be_i,
  input  logic                              pop_i,
  output logic [DEPTH-1:0][AW-1:0]          ent_addr_o,
  output logic [DEPTH-1:0][DW-1:0]          ent_data_o,
  output logic [DEPTH-1:0][DW/8-1:0]        ent_be_o,
  output logic [DEPTH-1:0]                  ent_vld_o,
  output logic [$clog2(DEPTH+1)-1:0]        cnt_o
);
  localparam int unsigned BW = DW / 8;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0]              cnt_q;
  logic [CW-1:0]              wr_idx;
  logic [DEPTH-1:0][AW-1:0]   addr_q;
  logic [DEPTH-1:0][DW-1:0]   data_q;
  logic [DEPTH-1:0][BW-1:0]   be_q;

  // slot 0 is always the oldest; a pop shifts everything down
  assign wr_idx = pop_i ? cnt_q - CW'(1) : cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam int unsigned SRC = (g < DEPTH - 1) ? g + 1 : g;
    logic [AW-1:0] nxt_addr;
    logic [DW-1:0] nxt_data;
    logic [BW-1:0] nxt_be;

    always_comb begin
      nxt_addr = addr_q[g];
      nxt_data = data_q[g];
      nxt_be   = be_q[g];
      if (pop_i) begin
        nxt_addr = addr_q[SRC];
        nxt_data = data_q[SRC];
        nxt_be   = be_q[SRC];
      end
      if (push_i && wr_idx == CW'(g)) begin
        nxt_addr = push_addr_i;
        nxt_data = push_data_i;
        nxt_be   = push_be_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
        be_q[g]   <= '0;
      end else begin
        addr_q[g] <= nxt_addr;
        data_q[g] <= nxt_data;
        be_q[g]   <= nxt_be;
      end
    end

    assign ent_vld_o[g] = (CW'(g) < cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (push_i && !pop_i)  cnt_q <= cnt_q + CW'(1);
    else if (pop_i && !push_i)  cnt_q <= cnt_q - CW'(1);
  end

  assign ent_addr_o = addr_q;
  assign ent_data_o = data_q;
  assign ent_be_o   = be_q;
  assign cnt_o      = cnt_q;

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && !pop_i && cnt_q == CW'(DEPTH)));
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
  assert_pop_frees_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic [AW-1:0]               ld_addr_i,
  input  logic [DW-1:0]               cache_data_i,
  input  logic [DEPTH-1:0][AW-1:0]    ent_addr_i,
  input  logic [DEPTH-1:0][DW-1:0]    ent_data_i,
  input  logic [DEPTH-1:0][DW/8-1:0]  ent_be_i,
  input  logic [DEPTH-1:0]            ent_vld_i,
  output logic [DW-1:0]               ld_data_o
);
  localparam int unsigned BW = DW / 8;

  // oldest to youngest so the youngest match wins per lane
  always_comb begin
    ld_data_o = cache_data_i;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld_i[i] && ent_addr_i[i] == ld_addr_i) begin
        for (int b = 0; b < BW; b++) begin
          if (ent_be_i[i][b]) ld_data_o[b*8 +: 8] = ent_data_i[i][b*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/sb_wsel.sv
module sb_wsel #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  sb_pkg::wsrc_e    src_i,
  input  logic [AW-1:0]    st_addr_i,
  input  logic [DW-1:0]    st_data_i,
  input  logic [DW/8-1:0]  st_be_i,
  input  logic [AW-1:0]    hd_addr_i,
  input  logic [DW-1:0]    hd_data_i,
  input  logic [DW/8-1:0]  hd_be_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic [DW/8-1:0]  wr_be_o
);
  always_comb begin
    wr_en_o   = 1'b0;
    wr_addr_o = hd_addr_i;
    wr_data_o = hd_data_i;
    wr_be_o   = hd_be_i;
    unique case (src_i)
      sb_pkg::WSRC_DIRECT: begin
        wr_en_o   = 1'b1;
        wr_addr_o = st_addr_i;
        wr_data_o = st_data_i;
        wr_be_o   = st_be_i;
      end
      sb_pkg::WSRC_DRAIN: wr_en_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  input  logic [DW/8-1:0] req_be_i,
  input  logic            req_owned_i,
  output logic            stall_o,
  output logic            full_o,
  output logic [DW-1:0]   load_data_o,
  output logic [AW-1:0]   cache_rd_addr_o,
  input  logic [DW-1:0]   cache_rd_data_i,
  output logic            drain_pending_o,
  output logic [AW-1:0]   drain_addr_o,
  input  logic            drain_owned_i,
  output logic            cache_wr_en_o,
  output logic [AW-1:0]   cache_wr_addr_o,
  output logic [DW-1:0]   cache_wr_data_o,
  output logic [DW/8-1:0] cache_wr_be_o
);
  import sb_pkg::*;
  localparam int unsigned BW = DW / 8;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic                     is_st, is_ld, empty, full, direct, drain, push;
  logic [CW-1:0]            cnt;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [DEPTH-1:0][BW-1:0] ent_be;
  logic [DEPTH-1:0]         ent_vld;
  wsrc_e                    wsrc;

  assign is_st  = req_valid_i & req_we_i;
  assign is_ld  = req_valid_i & ~req_we_i;
  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  // bypass only when nothing older is pending, preserving store order
  assign direct = is_st & empty & req_owned_i;
  assign drain  = ~empty & drain_owned_i;
  assign push   = is_st & ~direct & ~full;
  assign wsrc   = direct ? WSRC_DIRECT : (drain ? WSRC_DRAIN : WSRC_NONE);

  sb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_wdata_i),
    .push_be_i   (req_be_i),
    .pop_i       (drain),
    .ent_addr_o  (ent_addr),
    .ent_data_o  (ent_data),
    .ent_be_o    (ent_be),
    .ent_vld_o   (ent_vld),
    .cnt_o       (cnt)
  );

  sb_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
    .ld_addr_i    (req_addr_i),
    .cache_data_i (cache_rd_data_i),
    .ent_addr_i   (ent_addr),
    .ent_data_i   (ent_data),
    .ent_be_i     (ent_be),
    .ent_vld_i    (ent_vld),
    .ld_data_o    (load_data_o)
  );

  sb_wsel #(.AW(AW), .DW(DW)) u_wsel (
    .src_i     (wsrc),
    .st_addr_i (req_addr_i),
    .st_data_i (req_wdata_i),
    .st_be_i   (req_be_i),
    .hd_addr_i (ent_addr[0]),
    .hd_data_i (ent_data[0]),
    .hd_be_i   (ent_be[0]),
    .wr_en_o   (cache_wr_en_o),
    .wr_addr_o (cache_wr_addr_o),
    .wr_data_o (cache_wr_data_o),
    .wr_be_o   (cache_wr_be_o)
  );

  assign stall_o         = is_st & full;
  assign full_o          = full;
  assign cache_rd_addr_o = req_addr_i;
  assign drain_pending_o = ~empty;
  assign drain_addr_o    = ent_addr[0];

  assert_stall_no_grow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> cnt <= $past(cnt));
  assert_wr_needs_own_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_wr_en_o |-> (req_owned_i || drain_owned_i));
  assert_direct_only_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_wr_en_o && !drain_pending_o) |-> (is_st && req_owned_i && cache_wr_addr_o == req_addr_i));
  assert_owned_store_queued_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_st && !empty && !full && !drain_owned_i) |=> cnt == $past(cnt) + CW'(1));
  assert_fwd_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ld && ent_vld == '0) |-> load_data_o == cache_rd_data_i);
endmodule

// File: tb/tb_store_buffer.sv
module tb_store_buffer;
  localparam int AW = 8, DW = 32, BW = 4, DEPTH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_ni;
  logic            req_valid_i, req_we_i, req_owned_i, drain_owned_i;
  logic [AW-1:0]   req_addr_i;
  logic [DW-1:0]   req_wdata_i;
  logic [BW-1:0]   req_be_i;
  logic            stall_o, full_o, drain_pending_o, cache_wr_en_o;
  logic [DW-1:0]   load_data_o, cache_rd_data_i, cache_wr_data_o;
  logic [AW-1:0]   cache_rd_addr_o, drain_addr_o, cache_wr_addr_o;
  logic [BW-1:0]   cache_wr_be_o;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  assign cache_rd_data_i = mem[cache_rd_addr_o];

  store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_we_i(req_we_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_be_i(req_be_i), .req_owned_i(req_owned_i),
    .stall_o(stall_o), .full_o(full_o), .load_data_o(load_data_o),
    .cache_rd_addr_o(cache_rd_addr_o), .cache_rd_data_i(cache_rd_data_i),
    .drain_pending_o(drain_pending_o), .drain_addr_o(drain_addr_o),
    .drain_owned_i(drain_owned_i), .cache_wr_en_o(cache_wr_en_o),
    .cache_wr_addr_o(cache_wr_addr_o), .cache_wr_data_o(cache_wr_data_o),
    .cache_wr_be_o(cache_wr_be_o)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [BW-1:0] be;
  } ent_t;
  ent_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one cycle: drive at negedge, compare, model update at posedge
  task automatic step(input logic v, input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [BW-1:0] be,
                      input logic ro, input logic dro);
    bit st, ld, emp, fl, dir, drn, psh, wen;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd, ld_exp;
    logic [BW-1:0] wbe;
    string tag;
    req_valid_i = v; req_we_i = we; req_addr_i = a; req_wdata_i = d;
    req_be_i = be; req_owned_i = ro; drain_owned_i = dro;
    #1;
    st  = v && we;
    ld  = v && !we;
    emp = (q.size() == 0);
    fl  = (q.size() == DEPTH);
    dir = st && emp && ro;
    drn = !emp && dro;
    psh = st && !dir && !fl;
    wen = dir || drn;
    wa = dir ? a : (emp ? '0 : q[0].a);
    wd = dir ? d : (emp ? '0 : q[0].d);
    wbe = dir ? be : (emp ? '0 : q[0].be);
    ld_exp = mem[a];
    foreach (q[i]) if (q[i].a == a)
      for (int b = 0; b < BW; b++) if (q[i].be[b]) ld_exp[b*8 +: 8] = q[i].d[b*8 +: 8];

    chk(stall_o == (st && fl), ld ? "R8" : "R7", "stall_o", DW'(stall_o), DW'(st && fl));
    chk(full_o == fl, "R7", "full_o", DW'(full_o), DW'(fl));
    chk(drain_pending_o == !emp, "R2", "drain_pending_o", DW'(drain_pending_o), DW'(!emp));
    chk(cache_rd_addr_o == a, "R6", "cache_rd_addr_o", DW'(cache_rd_addr_o), DW'(a));
    tag = dir ? "R3" : (drn ? "R4" : ((st && ro && !emp) ? "R9" : "R5"));
    chk(cache_wr_en_o == wen, tag, "cache_wr_en_o", DW'(cache_wr_en_o), DW'(wen));
    if (wen && cache_wr_en_o) begin
      chk(cache_wr_addr_o == wa, tag, "cache_wr_addr_o", DW'(cache_wr_addr_o), DW'(wa));
      chk(cache_wr_data_o == wd, tag, "cache_wr_data_o", cache_wr_data_o, wd);
      chk(cache_wr_be_o == wbe, tag, "cache_wr_be_o", DW'(cache_wr_be_o), DW'(wbe));
    end
    if (ld) chk(load_data_o == ld_exp, "R6", "load_data_o", load_data_o, ld_exp);

    @(posedge clk);
    if (wen) for (int b = 0; b < BW; b++) if (wbe[b]) mem[wa][b*8 +: 8] = wd[b*8 +: 8];
    if (drn) void'(q.pop_front());
    if (psh) q.push_back('{a: a, d: d, be: be});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = i * 32'h0101_0101;
    rst_ni = 1'b0;
    req_valid_i = 0; req_we_i = 0; req_addr_i = '0; req_wdata_i = '0;
    req_be_i = '0; req_owned_i = 0; drain_owned_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state, with ownership inputs high to tempt a write
    req_owned_i = 1; drain_owned_i = 1; #1;
    chk(!stall_o && !full_o && !drain_pending_o && !cache_wr_en_o, "R1", "reset outputs",
        DW'({stall_o, full_o, drain_pending_o, cache_wr_en_o}), '0);
    req_owned_i = 0; drain_owned_i = 0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!drain_pending_o && !full_o && !cache_wr_en_o, "R1", "after reset",
        DW'({full_o, drain_pending_o, cache_wr_en_o}), '0);

    // R2 queue a store, R6 forward it
    step(1, 1, 8'd1, 32'h1111_1111, 4'hF, 0, 0);
    step(1, 0, 8'd1, '0, '0, 0, 0);
    // R6 partial overlap, youngest wins in low lanes
    step(1, 1, 8'd1, 32'hAABB_CCDD, 4'b0011, 0, 0);
    step(1, 0, 8'd1, '0, '0, 0, 0);
    step(1, 0, 8'd2, '0, '0, 0, 0);
    // R9 owned line with pending entries still queued
    step(1, 1, 8'd2, 32'h2222_2222, 4'b0100, 1, 0);
    step(1, 1, 8'd3, 32'h3333_3333, 4'hF, 0, 0);
    // R7 full: store refused, also with a drain in the same cycle
    step(1, 1, 8'd4, 32'h4444_4444, 4'hF, 0, 0);
    step(1, 1, 8'd4, 32'h4444_4444, 4'hF, 0, 1);
    // R8 load while not full still fine; fill again
    step(1, 0, 8'd4, '0, '0, 0, 0);
    step(1, 1, 8'd5, 32'h5555_5555, 4'hF, 0, 0);
    step(1, 0, 8'd5, '0, '0, 0, 0);
    // R4 drain in order
    for (int k = 0; k < DEPTH + 1; k++) step(0, 0, 8'd0, '0, '0, 0, 1);
    step(1, 0, 8'd1, '0, '0, 0, 0);
    // R3 direct write on empty owned store
    step(1, 1, 8'd6, 32'h6666_6666, 4'b1010, 1, 0);
    step(1, 0, 8'd6, '0, '0, 0, 0);
    // R5 no ownership, no write
    step(1, 1, 8'd7, 32'h7777_7777, 4'hF, 0, 0);
    step(0, 0, 8'd0, '0, '0, 0, 0);

    for (int ph = 0; ph < 8; ph++) begin
      for (int k = 0; k < 400; k++) begin
        logic dro;
        dro = (ph % 2 == 0) ? ($urandom % 5 == 0) : ($urandom % 3 != 0);
        step($urandom % 4 != 0, $urandom % 2, AW'($urandom % 8), $urandom,
             BW'($urandom % 16), $urandom % 3 == 0, dro);
      end
    end
    for (int k = 0; k < DEPTH; k++) step(0, 0, 8'd0, '0, '0, 0, 1);
    summary();
  end
endmodule